// File: doc/BRIEF.md
# Interlaced 4:2:2 Digital Video Stream Generator

This block produces the byte-wide digital video stream that a composite video encoder takes in. It runs at the 27 MHz word rate and sends two words per pixel. Active pixels go out as interleaved 4:2:2 samples in the order Cb, Y, Cr, Y, so one chroma pair serves two luma samples. Sync is not driven on separate pins. Each line opens with a four-word end-of-active-video code and a run of blanking words. A four-word start-of-active-video code follows, and then the active pixel words. The last word of each code carries the field, vertical-blanking and horizontal flags, together with their protection bits.

Pixels come from an upstream source as pairs, one 32-bit word per pair, through a ready/valid handshake. The block asks for a pair once every four active words, and only on lines that lie outside vertical blanking. If the source has nothing to give in that slot, the group of four words is sent as black. A line counter runs over the interlaced frame and produces the field and vertical-blanking flags from parameterised line ranges. The defaults give 1716 words per line, 720 active pixels and 525 lines, of which 487 are viewable.

Top module: `bt656_stream_gen`

## Requirements
- R1: While rst_n is low, vid_data is 0x10 and pix_ready is 0. After release, the first word on vid_data is word 0 of line 1.
- R2: A line is WORDS words long (default 1716). Words 0..3 of every line are 0xFF, 0x00, 0x00, XY with H=1.
- R3: The four words just before the first active word carry 0xFF, 0x00, 0x00, XY with H=0. The first active word is at index WORDS-2*ACT_PIX.
- R4: XY is {1, F, V, H, V^H, F^H, F^V, F^V^H}, with bit 7 first.
- R5: The line counter runs 1..LINES and advances when the word index wraps. F is 0 for lines F0_FIRST..F0_LAST and 1 otherwise. V is 1 for lines 1..VA_LAST and VB_FIRST..VB_LAST.
- R6: Every other word is a blanking word, including the active span of lines with V=1. A blanking word is 0x80 at an even word index and 0x10 at an odd one.
- R7: pix_ready is 1 only in the cycle before the first word of each four-word active group, and only on lines with V=0.
- R8: A pair accepted while pix_ready and pix_valid are both 1 goes out as Cb=pix_data[31:24], Y0=[23:16], Cr=[15:8], Y1=[7:0] on four consecutive words, and Cb appears in the cycle after acceptance.
- R9: If pix_valid is 0 in a ready slot, that group goes out as 0x80, 0x10, 0x80, 0x10. pix_valid and pix_data have no effect outside ready slots.
- R10: After line LINES the stream goes back to line 1 with no gap, and the frame repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock (27 MHz in use) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Source has a pixel pair |
| pix_data | input | 32 | Pixel pair {Cb, Y0, Cr, Y1} |
| pix_ready | output | 1 | Block takes a pair this cycle |
| vid_data | output | 8 | Output video word |

## Verification
Several events fall in the same cycle at the end of a line. The last Y1 word of a line is followed at once by the wrap of the word index, the step of the line counter and a new EAV whose F and V bits may both flip. At the last line of the frame, a frame wrap happens on top of this. The bench drives several whole frames with a reduced line geometry. It withholds pix_valid in some ready slots and holds it high with unrelated data between them. It also compares every word, including the XY code that follows a final pixel group, against a model built from the line ranges.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

   localparam logic [7:0] BLK_CHROMA = 8'h80;
   localparam logic [7:0] BLK_LUMA   = 8'h10;
   localparam logic [7:0] TRS_LEAD   = 8'hFF;
   localparam logic [7:0] TRS_ZERO   = 8'h00;

   typedef enum logic [1:0] {
      RG_EAV  = 2'd0,
      RG_HBLK = 2'd1,
      RG_SAV  = 2'd2,
      RG_ACT  = 2'd3
   } region_t;

   typedef struct packed {
      logic [7:0] cb;
      logic [7:0] y0;
      logic [7:0] cr;
      logic [7:0] y1;
   } pix_pair_t;

   function automatic logic [7:0] trs_xy(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

endpackage

// File: rtl/bt656_timing.sv
module bt656_timing
   import bt656_pkg::*;
#(
   parameter int WORDS      = 1716,
   parameter int ACT_WORDS  = 1440,
   parameter int LINES      = 525,
   parameter int F0_FIRST   = 4,
   parameter int F0_LAST    = 265,
   parameter int VA_LAST    = 19,
   parameter int VB_FIRST   = 264,
   parameter int VB_LAST    = 282,
   parameter bit INTERLACED = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   output region_t region,
   output logic [1:0] sub,
   output logic    odd,
   output logic    fld,
   output logic    vblk
);
   localparam int WW        = $clog2(WORDS);
   localparam int LW        = $clog2(LINES + 1);
   localparam int ACT_START = WORDS - ACT_WORDS;
   localparam int SAV_START = ACT_START - 4;

   logic [WW-1:0] word_q;
   logic [LW-1:0] line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         line_q <= LW'(1);
      end else if (word_q == WW'(WORDS - 1)) begin
         word_q <= '0;
         line_q <= (line_q == LW'(LINES)) ? LW'(1) : line_q + LW'(1);
      end else begin
         word_q <= word_q + WW'(1);
      end
   end

   always_comb begin
      if (word_q < WW'(4))                region = RG_EAV;
      else if (word_q < WW'(SAV_START))   region = RG_HBLK;
      else if (word_q < WW'(ACT_START))   region = RG_SAV;
      else                                region = RG_ACT;
   end

   assign sub  = word_q[1:0];
   assign odd  = word_q[0];
   assign vblk = (line_q <= LW'(VA_LAST)) ||
                 ((line_q >= LW'(VB_FIRST)) && (line_q <= LW'(VB_LAST)));

   generate
      if (INTERLACED) begin : g_fld
         assign fld = !((line_q >= LW'(F0_FIRST)) && (line_q <= LW'(F0_LAST)));
      end else begin : g_prog
         assign fld = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bt656_fmt.sv
module bt656_fmt
   import bt656_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  region_t    region,
   input  logic [1:0] sub,
   input  logic       odd,
   input  logic       fld,
   input  logic       vblk,
   input  logic       pix_valid,
   input  logic [31:0] pix_data,
   output logic       pix_ready,
   output logic [7:0] vid_data
);
   pix_pair_t  in_pair, hold_q;
   logic       have_q;
   logic [7:0] nxt;

   assign in_pair   = pix_pair_t'(pix_data);
   assign pix_ready = (region == RG_ACT) && !vblk && (sub == 2'd0);

   always_comb begin
      unique case (region)
         RG_EAV, RG_SAV: begin
            unique case (sub)
               2'd0:    nxt = TRS_LEAD;
               2'd3:    nxt = trs_xy(fld, vblk, region == RG_EAV);
               default: nxt = TRS_ZERO;
            endcase
         end
         RG_ACT: begin
            if (vblk) begin
               nxt = odd ? BLK_LUMA : BLK_CHROMA;
            end else begin
               unique case (sub)
                  2'd0:    nxt = pix_valid ? in_pair.cb : BLK_CHROMA;
                  2'd1:    nxt = have_q ? hold_q.y0 : BLK_LUMA;
                  2'd2:    nxt = have_q ? hold_q.cr : BLK_CHROMA;
                  default: nxt = have_q ? hold_q.y1 : BLK_LUMA;
               endcase
            end
         end
         default: nxt = odd ? BLK_LUMA : BLK_CHROMA;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vid_data <= BLK_LUMA;
         have_q   <= 1'b0;
         hold_q   <= '0;
      end else begin
         vid_data <= nxt;
         if (pix_ready) begin
            have_q <= pix_valid;
            if (pix_valid) hold_q <= in_pair;
         end
      end
   end

endmodule

// File: rtl/bt656_stream_gen.sv
module bt656_stream_gen
   import bt656_pkg::*;
#(
   parameter int WORDS      = 1716,
   parameter int ACT_PIX    = 720,
   parameter int LINES      = 525,
   parameter int F0_FIRST   = 4,
   parameter int F0_LAST    = 265,
   parameter int VA_LAST    = 19,
   parameter int VB_FIRST   = 264,
   parameter int VB_LAST    = 282,
   parameter bit INTERLACED = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pix_valid,
   input  logic [31:0] pix_data,
   output logic        pix_ready,
   output logic [7:0]  vid_data
);
   localparam int ACT_WORDS = 2 * ACT_PIX;

   generate
      if ((WORDS % 4) != 0 || (ACT_WORDS % 4) != 0) begin : g_bad_align
         $error("line and active lengths must be multiples of four words");
      end
      if (ACT_WORDS + 8 >= WORDS) begin : g_bad_blank
         $error("no room for timing codes and blanking");
      end
      if (VB_LAST > LINES || F0_LAST > LINES || VA_LAST >= VB_FIRST) begin : g_bad_lines
         $error("line ranges outside the frame");
      end
   endgenerate

   region_t    region;
   logic [1:0] sub;
   logic       odd, fld, vblk;

   bt656_timing #(
      .WORDS(WORDS), .ACT_WORDS(ACT_WORDS), .LINES(LINES),
      .F0_FIRST(F0_FIRST), .F0_LAST(F0_LAST), .VA_LAST(VA_LAST),
      .VB_FIRST(VB_FIRST), .VB_LAST(VB_LAST), .INTERLACED(INTERLACED)
   ) u_timing (
      .clk(clk), .rst_n(rst_n), .region(region), .sub(sub),
      .odd(odd), .fld(fld), .vblk(vblk)
   );

   bt656_fmt u_fmt (
      .clk(clk), .rst_n(rst_n), .region(region), .sub(sub), .odd(odd),
      .fld(fld), .vblk(vblk), .pix_valid(pix_valid), .pix_data(pix_data),
      .pix_ready(pix_ready), .vid_data(vid_data)
   );

endmodule

// File: rtl/bt656_stream_chk.sv
module bt656_stream_chk
   import bt656_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        pix_valid,
   input logic [31:0] pix_data,
   input logic        pix_ready,
   input logic [7:0]  vid_data,
   input region_t     region,
   input logic [1:0]  sub
);
   p_eav_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_EAV && sub == 2'd0) |=> vid_data == 8'hFF);

   p_sav_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_SAV && (sub == 2'd1 || sub == 2'd2)) |=> vid_data == 8'h00);

   p_sav_hflag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_SAV && sub == 2'd3) |=> !vid_data[4]);

   p_xy_prot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((region == RG_EAV || region == RG_SAV) && sub == 2'd3) |=>
      (vid_data[7] &&
       vid_data[3] == (vid_data[5] ^ vid_data[4]) &&
       vid_data[2] == (vid_data[6] ^ vid_data[4]) &&
       vid_data[1] == (vid_data[6] ^ vid_data[5]) &&
       vid_data[0] == (vid_data[6] ^ vid_data[5] ^ vid_data[4])));

   p_ready_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ready |=> !pix_ready);

   p_cb_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_ready && pix_valid) |=> vid_data == $past(pix_data[31:24]));

   p_cb_black_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_ready && !pix_valid) |=> vid_data == 8'h80);

endmodule

bind bt656_stream_gen bt656_stream_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
   .pix_ready(pix_ready), .vid_data(vid_data), .region(region), .sub(sub)
);

// File: tb/bt656_stream_gen_tb_top.sv
`timescale 1ns/1ps
module bt656_stream_gen_tb_top;
   localparam int WORDS  = 24;
   localparam int APIX   = 4;
   localparam int LINES  = 12;
   localparam int F0F    = 3;
   localparam int F0L    = 7;
   localparam int VAL    = 2;
   localparam int VBF    = 7;
   localparam int VBL    = 8;
   localparam int ASTART = WORDS - 2 * APIX;

   localparam logic [32:0] STIM [8] = '{
      {1'b1, 32'h11223344}, {1'b1, 32'hA5C35AE1}, {1'b0, 32'h99999999},
      {1'b1, 32'h01FE7F80}, {1'b1, 32'h40506070}, {1'b0, 32'h12345678},
      {1'b0, 32'hCAFEF00D}, {1'b1, 32'hEB10F010}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_valid = 1'b0;
   logic [31:0] pix_data = '0;
   logic        pix_ready;
   logic [7:0]  vid_data;

   int n_vec = 0, n_bad = 0;
   int ml, mw, tix, frames;
   logic        mhave;
   logic [31:0] mpair;

   always #2.5 clk = ~clk;

   bt656_stream_gen #(
      .WORDS(WORDS), .ACT_PIX(APIX), .LINES(LINES), .F0_FIRST(F0F), .F0_LAST(F0L),
      .VA_LAST(VAL), .VB_FIRST(VBF), .VB_LAST(VBL), .INTERLACED(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
      .pix_ready(pix_ready), .vid_data(vid_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s line %0d word %0d: got %0h expected %0h", req, ml, mw, act, exp);
      end
   endtask

   function automatic logic m_v(input int l);
      return (l <= VAL) || (l >= VBF && l <= VBL);
   endfunction

   function automatic logic m_f(input int l);
      return !(l >= F0F && l <= F0L);
   endfunction

   function automatic logic [7:0] m_xy(input int l, input logic h);
      logic f, v;
      f = m_f(l); v = m_v(l);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   function automatic logic m_ready(input int l, input int w);
      return (w >= ASTART) && !m_v(l) && ((w - ASTART) % 4 == 0);
   endfunction

   // drive inputs for the position the design is about to emit
   task automatic drive_pos();
      logic r;
      r = m_ready(ml, mw);
      chk("R7", 32'(pix_ready), 32'(r));
      if (r) begin
         pix_valid = STIM[tix % 8][32];
         pix_data  = STIM[tix % 8][31:0];
         mhave = pix_valid;
         mpair = pix_data;
         tix++;
      end else begin
         pix_valid = 1'b1;          // R9: ignored outside ready slots
         pix_data  = 32'hDEADBEEF;
      end
   endtask

   task automatic check_word();
      logic [7:0] e;
      string      req;
      int         ph;
      if (mw < 4) begin
         e = (mw == 0) ? 8'hFF : (mw == 3) ? m_xy(ml, 1'b1) : 8'h00;
         req = (mw == 3) ? ((frames > 0 && ml == 1) ? "R10" : "R4 R5") : "R2";
      end else if (mw >= ASTART - 4 && mw < ASTART) begin
         e = (mw == ASTART - 4) ? 8'hFF : (mw == ASTART - 1) ? m_xy(ml, 1'b0) : 8'h00;
         req = (mw == ASTART - 1) ? "R4 R5" : "R3";
      end else if (mw >= ASTART && !m_v(ml)) begin
         ph = (mw - ASTART) % 4;
         if (mhave) begin
            e = mpair[31 - 8 * ph -: 8];
            req = "R8";
         end else begin
            e = (ph % 2 == 1) ? 8'h10 : 8'h80;
            req = "R9";
         end
      end else begin
         e = (mw % 2 == 1) ? 8'h10 : 8'h80;
         req = "R6";
      end
      chk(req, 32'(vid_data), 32'(e));
   endtask

   task automatic step();
      @(negedge clk);
      check_word();
      mw++;
      if (mw == WORDS) begin
         mw = 0;
         if (ml == LINES) begin
            ml = 1;
            frames++;
         end else ml++;
      end
      drive_pos();
   endtask

   task automatic start_model();
      ml = 1; mw = 0; mhave = 1'b0; mpair = '0; frames = 0;
   endtask

   initial begin
      #(200000 * 5);
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      tix = 0;
      start_model();
      repeat (3) @(negedge clk);
      chk("R1", 32'(vid_data), 32'h10);
      chk("R1", 32'(pix_ready), 32'h0);
      rst_n = 1'b1;
      drive_pos();
      for (int i = 0; i < 2 * LINES * WORDS + 30; i++) step();

      // directed: reset in the middle of an active span
      while (!(mw == ASTART + 2 && !m_v(ml))) step();
      rst_n = 1'b0;
      pix_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R1", 32'(vid_data), 32'h10);
      chk("R1", 32'(pix_ready), 32'h0);
      rst_n = 1'b1;
      start_model();
      drive_pos();
      @(negedge clk);
      chk("R1", 32'(vid_data), 32'hFF);
      mw = 1;
      drive_pos();
      for (int i = 0; i < 3 * WORDS; i++) step();

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule